// File: doc/BRIEF.md
# Fully Parallel Type-II Normal-Basis Field Multiplier

This block multiplies two elements of the binary field GF(2^N). Operands and result are written in a type-II optimal normal basis, so 2N+1 must be prime and the basis must be of type II. The default is N = 11 (2N+1 = 23). Setting N = 233 (2N+1 = 467) gives the cryptographic field size. All N result bits are formed in the same pass and nothing is serialised.

Inside the block, a pure-wiring permutation first maps each operand from normal-basis order into an intermediate palindromic basis. A preprocessor then forms the N(N+1)/2 distinct product terms once. These are a_i·b_i for each i and a_i·b_j + a_j·b_i for each pair i < j, which gives 27261 terms when N = 233. N identical XOR trees each collect the terms that land on their output. A second copy of the same permutation component, set to inverse mode, returns the sum to normal-basis order. The term-to-tree mapping and both permutations are computed at elaboration from N.

Data enters and leaves through valid/ready streams:
- A word moves on any rising edge where both valid and ready are high.
- The internal pipeline advances only when the output register is empty or is being drained.
- When the consumer holds `out_ready` low while a result is pending, the result is held, `in_ready` drops, and no new operand pair is taken.
- A producer may hold `in_valid` high and wait for `in_ready`.

Top module: `onb2_mul`

## Requirements
- R1: For any operand pair, `out_p` equals the field product of `in_a` and `in_b`. Bit k of each word is the coefficient of the k-th conjugate β^(2^k) of the normal element.
- R2: If either operand is all zeros, the product is all zeros.
- R3: The all-ones word is the multiplicative unit: a·(all-ones) = a.
- R4: Squaring is a cyclic rotation. For a·a, result bit k equals a bit k-1 for k ≥ 1, and result bit 0 equals a bit N-1.
- R5: The product does not depend on operand order: a·b = b·a.
- R6: When no stall occurs, a result leaves LAT = REG_TERMS + REG_OUT rising edges after its operands are presented, counting the accepting edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_p` and `out_valid` hold their values and `in_ready` is low.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: Under any pattern of back-pressure, each accepted operand pair yields exactly one result, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block takes the operand pair on this edge if valid |
| in_a | input | N | First operand, normal basis |
| in_b | input | N | Second operand, normal basis |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product on this edge if valid |
| out_p | output | N | Product, normal basis |

## Verification
Random operand pairs are checked against a reference model in the bench. That model expands each operand into powers of a primitive (2N+1)-th root of unity and reduces a cyclic convolution, so it shares no step with the pairwise-term decomposition. Zero operands expose terms that leak in where none should exist. The all-ones unit and self-squaring expose any misplaced permutation slot, since both must reproduce the input exactly or rotated by one. Swapped operands expose any asymmetry in how the paired cross terms are wired. Spaced single transfers measure latency, while back-to-back streams under random consumer stalls show that results are held, in order and never duplicated.

// File: rtl/onb2_pkg.sv
package onb2_pkg;

  // 2^k mod p
  function automatic int pow2_mod(input int k, input int p);
    int r;
    r = 1;
    for (int s = 0; s < k; s++) r = (r * 2) % p;
    return r;
  endfunction

  // fold an exponent 1..p-1 onto the palindromic index 1..(p-1)/2
  function automatic int fold_idx(input int m, input int p);
    return (m > (p - 1) / 2) ? (p - m) : m;
  endfunction

  // intermediate-basis slot (1..n) holding normal-basis coefficient k
  function automatic int nb_slot(input int k, input int n);
    return fold_idx(pow2_mod(k, 2 * n + 1), 2 * n + 1);
  endfunction

  // flat index of term (i,j), 1 <= i <= j <= n
  function automatic int term_idx(input int i, input int j, input int n);
    return (i - 1) * n - ((i - 1) * (i - 2)) / 2 + (j - i);
  endfunction

  // does term (i,j) contribute to intermediate output k
  function automatic bit feeds(input int i, input int j, input int k, input int n);
    int p;
    p = 2 * n + 1;
    if (i == j) return fold_idx(2 * i, p) == k;
    return (fold_idx(i + j, p) == k) || ((j - i) == k);
  endfunction

endpackage

// File: rtl/onb2_perm.sv
module onb2_perm #(
  parameter int N       = 11,
  parameter bit INVERSE = 1'b0
) (
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  import onb2_pkg::*;

  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam int S = nb_slot(k, N) - 1;
    if (INVERSE) begin : g_inv
      assign dout[k] = din[S];
    end else begin : g_fwd
      assign dout[S] = din[k];
    end
  end
endmodule

// File: rtl/onb2_terms.sv
module onb2_terms #(
  parameter int N  = 11,
  localparam int NT = N * (N + 1) / 2
) (
  input  logic [N-1:0]  a,
  input  logic [N-1:0]  b,
  output logic [NT-1:0] t
);
  import onb2_pkg::*;

  for (genvar gi = 1; gi <= N; gi++) begin : g_row
    for (genvar gj = gi; gj <= N; gj++) begin : g_col
      localparam int IDX = term_idx(gi, gj, N);
      if (gi == gj) begin : g_diag
        assign t[IDX] = a[gi-1] & b[gi-1];
      end else begin : g_pair
        assign t[IDX] = (a[gi-1] & b[gj-1]) ^ (a[gj-1] & b[gi-1]);
      end
    end
  end
endmodule

// File: rtl/onb2_xor_tree.sv
module onb2_xor_tree #(
  parameter int N  = 11,
  parameter int K  = 1,
  localparam int NT = N * (N + 1) / 2
) (
  input  logic [NT-1:0] terms,
  output logic          bit_o
);
  import onb2_pkg::*;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 1; i <= N; i++) begin
      for (int j = i; j <= N; j++) begin
        if (feeds(i, j, K, N)) acc = acc ^ terms[term_idx(i, j, N)];
      end
    end
    bit_o = acc;
  end
endmodule

// File: rtl/onb2_stage.sv
module onb2_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         vin,
  input  logic [W-1:0] din,
  output logic         vout,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout <= 1'b0;
      dout <= '0;
    end else if (en) begin
      vout <= vin;
      dout <= din;
    end
  end

  a_r6_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (vout == $past(vin)));

  a_r7_stage_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(dout) && $stable(vout)));
endmodule

// File: rtl/onb2_mul.sv
module onb2_mul #(
  parameter int N         = 11,
  parameter bit REG_TERMS = 1'b1,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_p
);
  localparam int NT = N * (N + 1) / 2;

  logic [N-1:0]  a_p, b_p, c_int, c_nb;
  logic [NT-1:0] t_raw, t_q;
  logic          v1, adv;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  onb2_perm #(.N(N), .INVERSE(1'b0)) u_perm_a (.din(in_a), .dout(a_p));
  onb2_perm #(.N(N), .INVERSE(1'b0)) u_perm_b (.din(in_b), .dout(b_p));

  onb2_terms #(.N(N)) u_terms (.a(a_p), .b(b_p), .t(t_raw));

  if (REG_TERMS) begin : g_treg
    onb2_stage #(.W(NT)) u_stage (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .vin(in_valid), .din(t_raw), .vout(v1), .dout(t_q));
  end else begin : g_tcomb
    assign t_q = t_raw;
    assign v1  = in_valid;
  end

  for (genvar k = 1; k <= N; k++) begin : g_tree
    onb2_xor_tree #(.N(N), .K(k)) u_tree (.terms(t_q), .bit_o(c_int[k-1]));
  end

  onb2_perm #(.N(N), .INVERSE(1'b1)) u_iperm (.din(c_int), .dout(c_nb));

  if (REG_OUT) begin : g_oreg
    onb2_stage #(.W(N)) u_stage (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .vin(v1), .din(c_nb), .vout(out_valid), .dout(out_p));
  end else begin : g_ocomb
    assign out_valid = v1;
    assign out_p     = c_nb;
  end

  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_p)));

  a_r1_perm_weight: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(a_p) == $countones(in_a)) && ($countones(c_nb) == $countones(c_int)));

  a_r2_zero_terms: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_p == '0) || (b_p == '0)) |-> (t_raw == '0));
endmodule

// File: tb/onb2_mul_test.sv
module onb2_mul_test;
  localparam int N   = 11;
  localparam int P   = 2 * N + 1;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, in_valid, in_ready, out_valid, out_ready;
  logic [N-1:0] in_a, in_b, out_p;

  onb2_mul #(.N(N), .REG_TERMS(1'b1), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_p(out_p));

  int total = 0, bad = 0, cyc = 0, ready_mode = 0;
  bit finished = 0;
  logic [N-1:0] q_exp[$];
  string        q_req[$];
  int           q_acc[$];
  bit           q_lat[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] rnd();
    int unsigned r;
    r = $urandom;
    return r[N-1:0];
  endfunction

  // reference: expand in powers of a primitive P-th root, cyclic convolution
  function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [P-1:0] ga, gb, gc;
    logic [N-1:0] r;
    int e;
    ga = '0; gb = '0; gc = '0;
    for (int k = 0; k < N; k++) begin
      e = 1;
      for (int s = 0; s < k; s++) e = (e * 2) % P;
      ga[e] ^= a[k]; ga[P-e] ^= a[k];
      gb[e] ^= b[k]; gb[P-e] ^= b[k];
    end
    for (int i = 0; i < P; i++)
      for (int j = 0; j < P; j++)
        if (ga[i] && gb[j]) gc[(i + j) % P] ^= 1'b1;
    for (int k = 0; k < N; k++) begin
      e = 1;
      for (int s = 0; s < k; s++) e = (e * 2) % P;
      r[k] = gc[e] ^ gc[0];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b,
                      input string req, input logic [N-1:0] exp, input bit lat);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    q_exp.push_back(exp); q_req.push_back(req); q_acc.push_back(cyc); q_lat.push_back(lat);
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    bit prev_stall;
    logic [N-1:0] prev_data;
    logic [N-1:0] e;
    string rq;
    int acc;
    bit lt;
    prev_stall = 1'b0;
    prev_data = '0;
    out_ready = 1'b1;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = (($urandom % 3) != 0);
        default: out_ready = 1'b0;
      endcase
      #1;
      if (prev_stall) // R7: stalled result held
        check(out_valid && (out_p == prev_data), "R7", out_p, prev_data);
      if (out_valid && !out_ready) // R7: no acceptance while stalled
        check(!in_ready, "R7", N'(in_ready), '0);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_p;
      if (out_valid && out_ready) begin
        if (q_exp.size() == 0) begin
          check(1'b0, "R9", out_p, '0);
        end else begin
          e = q_exp.pop_front(); rq = q_req.pop_front();
          acc = q_acc.pop_front(); lt = q_lat.pop_front();
          check(out_p == e, rq, out_p, e);
          if (lt) check((cyc - acc) == LAT - 1, "R6", N'(cyc - acc), N'(LAT - 1));
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", q_exp.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b;
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R8", N'(out_valid), '0);
    check(in_ready == 1'b1, "R8", N'(in_ready), N'(1));
    @(negedge clk) rst_n = 1'b1;

    // R6: spaced single transfers for latency
    ready_mode = 0;
    for (int n = 0; n < 4; n++) begin
      a = rnd(); b = rnd();
      send(a, b, "R1", ref_mul(a, b), 1'b1);
      repeat (LAT + 2) @(posedge clk);
    end
    // R2: zero operands
    send('0, rnd(), "R2", '0, 1'b0);
    send(rnd(), '0, "R2", '0, 1'b0);
    send('0, '0, "R2", '0, 1'b0);
    // R3: all-ones unit
    for (int n = 0; n < 4; n++) begin
      a = rnd();
      send(a, '1, "R3", a, 1'b0);
      send('1, a, "R3", a, 1'b0);
    end
    send('1, '1, "R3", '1, 1'b0);
    send(N'(1), '1, "R3", N'(1), 1'b0);
    // R4: squaring rotates by one
    for (int n = 0; n < 6; n++) begin
      a = (n == 0) ? N'(1) : rnd();
      send(a, a, "R4", {a[N-2:0], a[N-1]}, 1'b0);
    end
    // R5: swapped operands give same product
    for (int n = 0; n < 6; n++) begin
      a = rnd(); b = rnd();
      send(b, a, "R5", ref_mul(a, b), 1'b0);
    end
    // R1: back-to-back random stream
    for (int n = 0; n < 60; n++) begin
      a = rnd(); b = rnd();
      send(a, b, "R1", ref_mul(a, b), 1'b0);
    end
    // R9 / R7: random back-pressure
    ready_mode = 1;
    for (int n = 0; n < 80; n++) begin
      a = rnd(); b = rnd();
      send(a, b, "R9", ref_mul(a, b), 1'b0);
    end
    while (q_exp.size() != 0) @(posedge clk);
    ready_mode = 0;
    repeat (4) @(posedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule